// File: doc/BRIEF.md
# Machine-Level Trap and Interrupt Controller

This block sits beside the issue stage of a simple in-order core. It holds the machine-level trap state: the global interrupt enable and its saved copy, the trap base address, the external interrupt enable and pending bits, the saved return PC and the cause word. Each cycle it looks at three event sources. These are a synchronous exception reported by the pipeline, the external interrupt line, and a return-from-trap instruction. From these it decides whether the fetch PC must be redirected, and where to.

When the external interrupt is enabled and pending, the instruction presented at issue is cancelled before it executes, and its own PC is saved. After the handler returns, that instruction therefore runs exactly once. The return instruction jumps to the saved PC exactly as stored. To resume past a faulting instruction, software rewrites the saved PC before returning. All state is reached through one CSR instruction port, which supports write, bit-set, bit-clear and pure read. The port returns the old value combinationally.

Top module: `mtrap_ctrl`

## Requirements
- R1: After reset, status (0x300), enable (0x304), return PC (0x341) and cause (0x342) read 0, the trap base (0x305) reads RESET_VEC, and no redirect is signalled.
- R2: A CSR access with csrValid high presents the old register value on csrRdata in the same cycle. The opcode selects the update applied at the next edge: 00 read only, 01 write, 10 set the bits given in csrWdata, 11 clear them.
- R3: Return PC bit 0 and trap-base bits 1:0 always read 0, and every trap target has its two low bits zero.
- R4: With status bit 3 (global enable) set, enable bit 11 set, extIrq high and instrValid high, the unit raises redirectValid and killInstr in that cycle, with redirectPc equal to the trap base. After the edge, the return PC holds instrPc and the cause reads 0x8000000B.
- R5: If status bit 3 or enable bit 11 is clear, or instrValid is low, extIrq causes no redirect and no kill, and no trap register changes.
- R6: An exception (excValid) redirects to the trap base in the same cycle and kills the instruction. After the edge, the return PC holds excPc and the cause holds excCause zero-extended, with bit 31 clear.
- R7: When an exception and a takeable interrupt coincide, the exception is taken and the return PC receives excPc.
- R8: On any trap entry, status bit 7 (saved enable) takes the old bit 3, and bit 3 is cleared.
- R9: A return (mretValid) redirects to the stored return PC without kill. After the edge, status bit 3 takes the old bit 7, and bit 7 becomes 1.
- R10: A software write to the return PC followed by a return redirects to the newly written value.
- R11: The pending register (0x344) reads extIrq at bit 11 and zero elsewhere, and writes to it have no effect.
- R12: A CSR write presented in the same cycle as a trap entry or a return is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csrValid | input | 1 | CSR instruction at this cycle |
| csrOp | input | 2 | 00 read, 01 write, 10 set, 11 clear |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | 32 | Source operand of the CSR instruction |
| csrRdata | output | 32 | Old value of the addressed CSR |
| excValid | input | 1 | Synchronous exception raised |
| excCause | input | 5 | Exception cause code |
| excPc | input | 32 | PC of the faulting instruction |
| instrValid | input | 1 | An instruction is about to execute |
| instrPc | input | 32 | PC of that instruction |
| mretValid | input | 1 | Return-from-trap instruction at this cycle |
| extIrq | input | 1 | External interrupt line, level |
| redirectValid | output | 1 | Fetch must restart at redirectPc |
| redirectPc | output | 32 | Trap base on entry, saved PC on return |
| killInstr | output | 1 | Cancel the current instruction |

## Verification
The bench sweeps every combination of global enable, external enable, interrupt line and exception request. The combinations it targets are an interrupt arriving while either enable is off, and an exception colliding with a live interrupt. A design with a wrong mask would trap when masked. A design with a wrong priority would save instrPc or write the interrupt cause where the exception should win. The saved-enable shuffle is checked after both entry and return, because a design that skips setting bit 7 on return would leave interrupts off after the second nested-free handler. Writing an odd return PC, advancing it before a return, and writing CSRs during a trap catch a design that keeps bit 0, ignores the new value, or lets the CSR write override the trap update.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

  localparam logic [11:0] ADDR_STATUS = 12'h300;
  localparam logic [11:0] ADDR_ENABLE = 12'h304;
  localparam logic [11:0] ADDR_BASE   = 12'h305;
  localparam logic [11:0] ADDR_RETPC  = 12'h341;
  localparam logic [11:0] ADDR_CAUSE  = 12'h342;
  localparam logic [11:0] ADDR_PEND   = 12'h344;

  localparam int GIE_BIT   = 3;
  localparam int SGIE_BIT  = 7;
  localparam int EXT_BIT   = 11;
  localparam int IRQ_CODE  = 11;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  typedef struct packed {
    logic enterTrap;
    logic isIrq;
    logic doRet;
    logic csrWe;
  } trap_strobe_t;

endpackage

// File: rtl/mtrap_ctl.sv
module mtrap_ctl
  import mtrap_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         excValid,
  input  logic         instrValid,
  input  logic         mretValid,
  input  logic         csrValid,
  input  logic [1:0]   csrOp,
  input  logic         extIrq,
  input  logic         gieBit,
  input  logic         extEnBit,
  output trap_strobe_t strobe
);

  logic excTake, irqTake, retTake;

  always_comb begin
    excTake = excValid;
    irqTake = !excValid && instrValid && extIrq && gieBit && extEnBit;
    retTake = mretValid && !excTake && !irqTake;
    strobe.enterTrap = excTake || irqTake;
    strobe.isIrq     = irqTake;
    strobe.doRet     = retTake;
    strobe.csrWe     = csrValid && (csr_op_e'(csrOp) != OP_READ)
                       && !excTake && !irqTake && !mretValid;
  end

  // R7: at most one event kind wins per cycle
  a_r7_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.enterTrap && !strobe.isIrq, strobe.isIrq, strobe.doRet}));

  // R5: interrupt only when both enables and the line are up
  a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.isIrq |-> (gieBit && extEnBit && extIrq && instrValid));

  // R12: no CSR update while a trap or return is in progress
  a_r12_csr_drop: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.csrWe |-> !(excValid || mretValid || strobe.enterTrap));

endmodule

// File: rtl/mtrap_dp.sv
module mtrap_dp
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CAUSE_W = 5,
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  trap_strobe_t       strobe,
  input  logic [11:0]        csrAddr,
  input  logic [1:0]         csrOp,
  input  logic [XLEN-1:0]    csrWdata,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [XLEN-1:0]    excPc,
  input  logic [XLEN-1:0]    instrPc,
  input  logic               extIrq,
  output logic [XLEN-1:0]    csrRdata,
  output logic               gieBit,
  output logic               extEnBit,
  output logic [XLEN-1:0]    redirectPc
);

  localparam int PAD_W = XLEN - 1 - CAUSE_W;

  logic            gieR, sgieR, extEnR;
  logic [XLEN-1:2] baseR;
  logic [XLEN-1:1] retPcR;
  logic [XLEN-1:0] causeR;
  logic [XLEN-1:0] newVal;
  logic [XLEN-1:0] savePc;
  logic [XLEN-1:0] saveCause;

  always_comb begin
    csrRdata = '0;
    unique case (csrAddr)
      ADDR_STATUS: begin
        csrRdata[GIE_BIT]  = gieR;
        csrRdata[SGIE_BIT] = sgieR;
      end
      ADDR_ENABLE: csrRdata[EXT_BIT] = extEnR;
      ADDR_BASE:   csrRdata = {baseR, 2'b00};
      ADDR_RETPC:  csrRdata = {retPcR, 1'b0};
      ADDR_CAUSE:  csrRdata = causeR;
      ADDR_PEND:   csrRdata[EXT_BIT] = extIrq;
      default:     csrRdata = '0;
    endcase
  end

  always_comb begin
    unique case (csr_op_e'(csrOp))
      OP_WRITE: newVal = csrWdata;
      OP_SET:   newVal = csrRdata | csrWdata;
      OP_CLEAR: newVal = csrRdata & ~csrWdata;
      default:  newVal = csrRdata;
    endcase
  end

  always_comb begin
    if (strobe.isIrq) begin
      savePc    = instrPc;
      saveCause = {1'b1, (XLEN-1)'(IRQ_CODE)};
    end else begin
      savePc    = excPc;
      saveCause = {1'b0, {PAD_W{1'b0}}, excCause};
    end
    redirectPc = strobe.enterTrap ? {baseR, 2'b00} : {retPcR, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gieR   <= 1'b0;
      sgieR  <= 1'b0;
      extEnR <= 1'b0;
      baseR  <= RESET_VEC[XLEN-1:2];
      retPcR <= '0;
      causeR <= '0;
    end else if (strobe.enterTrap) begin
      sgieR  <= gieR;
      gieR   <= 1'b0;
      retPcR <= savePc[XLEN-1:1];
      causeR <= saveCause;
    end else if (strobe.doRet) begin
      gieR  <= sgieR;
      sgieR <= 1'b1;
    end else if (strobe.csrWe) begin
      unique case (csrAddr)
        ADDR_STATUS: begin
          gieR  <= newVal[GIE_BIT];
          sgieR <= newVal[SGIE_BIT];
        end
        ADDR_ENABLE: extEnR <= newVal[EXT_BIT];
        ADDR_BASE:   baseR  <= newVal[XLEN-1:2];
        ADDR_RETPC:  retPcR <= newVal[XLEN-1:1];
        ADDR_CAUSE:  causeR <= newVal;
        default: ;
      endcase
    end
  end

  assign gieBit   = gieR;
  assign extEnBit = extEnR;

  // R8: entry saves and clears the global enable
  a_r8_entry_enable: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.enterTrap |=> (!gieR && sgieR == $past(gieR)));

  // R9: return restores the enable and sets the saved copy
  a_r9_return_enable: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doRet |=> (gieR == $past(sgieR) && sgieR));

  // R4: interrupt entry records the interrupt cause and the issue PC
  a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.enterTrap && strobe.isIrq) |=>
      (causeR[XLEN-1] && {retPcR, 1'b0} == {$past(instrPc[XLEN-1:1]), 1'b0}));

  // R6: exception entry records a cause with the top bit clear
  a_r6_exc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.enterTrap && !strobe.isIrq) |=>
      (!causeR[XLEN-1] && causeR[CAUSE_W-1:0] == $past(excCause)));

endmodule

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CAUSE_W = 5,
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csrValid,
  input  logic [1:0]         csrOp,
  input  logic [11:0]        csrAddr,
  input  logic [XLEN-1:0]    csrWdata,
  output logic [XLEN-1:0]    csrRdata,
  input  logic               excValid,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [XLEN-1:0]    excPc,
  input  logic               instrValid,
  input  logic [XLEN-1:0]    instrPc,
  input  logic               mretValid,
  input  logic               extIrq,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc,
  output logic               killInstr
);

  trap_strobe_t strobe;
  logic gieBit, extEnBit;

  mtrap_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .excValid(excValid), .instrValid(instrValid), .mretValid(mretValid),
    .csrValid(csrValid), .csrOp(csrOp), .extIrq(extIrq),
    .gieBit(gieBit), .extEnBit(extEnBit), .strobe(strobe)
  );

  mtrap_dp #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .RESET_VEC(RESET_VEC)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .csrAddr(csrAddr), .csrOp(csrOp), .csrWdata(csrWdata),
    .excCause(excCause), .excPc(excPc), .instrPc(instrPc), .extIrq(extIrq),
    .csrRdata(csrRdata), .gieBit(gieBit), .extEnBit(extEnBit),
    .redirectPc(redirectPc)
  );

  assign redirectValid = strobe.enterTrap || strobe.doRet;
  assign killInstr     = strobe.enterTrap;

  // R3: every trap target is word aligned
  a_r3_target_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (redirectValid && killInstr) |-> (redirectPc[1:0] == 2'b00));

endmodule

// File: tb/mtrap_ctrl_tb.sv
`timescale 1ns/1ps
module mtrap_ctrl_tb;

  localparam logic [31:0] RVEC = 32'h0000_0040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csrValid = 1'b0;
  logic [1:0]  csrOp = 2'b00;
  logic [11:0] csrAddr = '0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata;
  logic        excValid = 1'b0;
  logic [4:0]  excCause = '0;
  logic [31:0] excPc = '0;
  logic        instrValid = 1'b0;
  logic [31:0] instrPc = '0;
  logic        mretValid = 1'b0;
  logic        extIrq = 1'b0;
  logic        redirectValid;
  logic [31:0] redirectPc;
  logic        killInstr;

  int nChecks = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  mtrap_ctrl #(.RESET_VEC(RVEC)) u_dut (
    .clk(clk), .rst_n(rst_n), .csrValid(csrValid), .csrOp(csrOp),
    .csrAddr(csrAddr), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .excValid(excValid), .excCause(excCause), .excPc(excPc),
    .instrValid(instrValid), .instrPc(instrPc), .mretValid(mretValid),
    .extIrq(extIrq), .redirectValid(redirectValid), .redirectPc(redirectPc),
    .killInstr(killInstr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic rdCsr(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    csrValid = 1'b1; csrOp = 2'b00; csrAddr = a;
    #0.5 v = csrRdata;
    csrValid = 1'b0;
  endtask

  task automatic wrCsr(input logic [1:0] op, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csrValid = 1'b1; csrOp = op; csrAddr = a; csrWdata = d;
    @(posedge clk); #0.5;
    csrValid = 1'b0;
  endtask

  task automatic expectCsr(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rdCsr(a, v);
    checkEq(tag, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;

    // R1 reset state
    #0.5 checkEq("R1 no redirect", {31'b0, redirectValid}, 32'h0);
    expectCsr("R1 status", 12'h300, 32'h0);
    expectCsr("R1 enable", 12'h304, 32'h0);
    expectCsr("R1 base", 12'h305, RVEC);
    expectCsr("R1 retpc", 12'h341, 32'h0);
    expectCsr("R1 cause", 12'h342, 32'h0);

    // R2 write / set / clear / read, old value returned
    wrCsr(2'b01, 12'h342, 32'h0000_F0F0);
    expectCsr("R2 write", 12'h342, 32'h0000_F0F0);
    @(negedge clk);
    csrValid = 1'b1; csrOp = 2'b10; csrAddr = 12'h342; csrWdata = 32'h0000_000F;
    #0.5 checkEq("R2 old value on set", csrRdata, 32'h0000_F0F0);
    @(posedge clk); #0.5 csrValid = 1'b0;
    expectCsr("R2 set", 12'h342, 32'h0000_F0FF);
    wrCsr(2'b11, 12'h342, 32'h0000_00F0);
    expectCsr("R2 clear", 12'h342, 32'h0000_F00F);
    wrCsr(2'b00, 12'h342, 32'hFFFF_FFFF);
    expectCsr("R2 read-only op", 12'h342, 32'h0000_F00F);

    // R3 alignment
    wrCsr(2'b01, 12'h305, 32'h8000_0103);
    expectCsr("R3 base low bits", 12'h305, 32'h8000_0100);
    wrCsr(2'b01, 12'h341, 32'h0000_1235);
    expectCsr("R3 retpc bit0", 12'h341, 32'h0000_1234);

    // R11 pending register
    wrCsr(2'b01, 12'h344, 32'hFFFF_FFFF);
    expectCsr("R11 pend idle", 12'h344, 32'h0);
    @(negedge clk); extIrq = 1'b1;
    expectCsr("R11 pend live", 12'h344, 32'h0000_0800);
    extIrq = 1'b0;

    // R4 R5 R6 R7 R8 sweep
    for (int idx = 0; idx < 16; idx++) begin
      bit gie, een, irq, exc, take, isIrq;
      logic [31:0] ipc, epc, expPc, expCause, expStat;
      gie = idx[0]; een = idx[1]; irq = idx[2]; exc = idx[3];
      ipc = 32'h2000 + idx * 8;
      epc = 32'h3000 + idx * 8;
      wrCsr(2'b01, 12'h300, {24'b0, 4'b0, gie, 3'b0});
      wrCsr(2'b01, 12'h304, {20'b0, een, 11'b0});
      wrCsr(2'b01, 12'h341, 32'h0000_0100);
      wrCsr(2'b01, 12'h342, 32'h0);
      isIrq = !exc && gie && een && irq;
      take = exc || isIrq;
      @(negedge clk);
      instrValid = 1'b1; instrPc = ipc; extIrq = irq;
      excValid = exc; excPc = epc; excCause = 5'(idx + 1);
      #0.5;
      checkEq($sformatf("R5 R6 redirect case %0d", idx), {31'b0, redirectValid}, {31'b0, take});
      checkEq($sformatf("R4 kill case %0d", idx), {31'b0, killInstr}, {31'b0, take});
      if (take) checkEq($sformatf("R3 target case %0d", idx), redirectPc, 32'h8000_0100);
      @(posedge clk); #0.5;
      instrValid = 1'b0; extIrq = 1'b0; excValid = 1'b0;
      expPc    = !take ? 32'h100 : (exc ? epc : ipc);
      expCause = !take ? 32'h0 : (exc ? 32'(idx + 1) : 32'h8000_000B);
      expStat  = take ? {24'b0, gie, 7'b0} : {28'b0, gie, 3'b0};
      expectCsr($sformatf("R7 retpc case %0d", idx), 12'h341, expPc);
      expectCsr($sformatf("R4 R6 cause case %0d", idx), 12'h342, expCause);
      expectCsr($sformatf("R8 status case %0d", idx), 12'h300, expStat);
    end

    // R9 return
    wrCsr(2'b01, 12'h300, 32'h0000_0080);
    wrCsr(2'b01, 12'h341, 32'h0000_1234);
    @(negedge clk); mretValid = 1'b1;
    #0.5;
    checkEq("R9 return redirect", {31'b0, redirectValid}, 32'h1);
    checkEq("R9 return no kill", {31'b0, killInstr}, 32'h0);
    checkEq("R9 return target", redirectPc, 32'h0000_1234);
    @(posedge clk); #0.5 mretValid = 1'b0;
    expectCsr("R9 status after return", 12'h300, 32'h0000_0088);

    // R10 software-advanced return PC
    wrCsr(2'b01, 12'h300, 32'h0);
    @(negedge clk); csrValid = 1'b1; csrOp = 2'b01; csrAddr = 12'h341; csrWdata = 32'h0000_1238;
    @(posedge clk); #0.5 csrValid = 1'b0;
    @(negedge clk); mretValid = 1'b1;
    #0.5 checkEq("R10 new target", redirectPc, 32'h0000_1238);
    @(posedge clk); #0.5 mretValid = 1'b0;
    expectCsr("R9 status enable from saved 0", 12'h300, 32'h0000_0080);

    // R12 CSR write dropped during trap and during return
    @(negedge clk);
    csrValid = 1'b1; csrOp = 2'b01; csrAddr = 12'h341; csrWdata = 32'h0000_5550;
    excValid = 1'b1; excPc = 32'h0000_4440; excCause = 5'd2;
    @(posedge clk); #0.5 csrValid = 1'b0; excValid = 1'b0;
    expectCsr("R12 write lost to exception", 12'h341, 32'h0000_4440);
    @(negedge clk);
    csrValid = 1'b1; csrOp = 2'b01; csrAddr = 12'h342; csrWdata = 32'h0000_0777;
    mretValid = 1'b1;
    @(posedge clk); #0.5 csrValid = 1'b0; mretValid = 1'b0;
    expectCsr("R12 write lost to return", 12'h342, 32'h0000_0002);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule